// File: doc/BRIEF.md
# Three-Way Set-Associative Cache Lookup

This block is the tag-compare and word-select core of a physically indexed, physically tagged cache with 16-byte lines and three ways per set. A 32-bit byte address is split into tag, set, word and byte fields. The set field reads the tag store, valid bit and line store of all three ways at once. The stored tags are compared with the address tag, and one clock later the block reports whether a way matched, which way it was, and the addressed 32-bit word of that way.

A second port writes lines into the cache under a 16-bit byte mask. When a line is already present, a fill updates it in place. Otherwise the fill goes to the lowest-numbered empty way of the set. When the set is full, a round-robin pointer kept for each set picks the victim and steps through 0, 1, 2 and back to 0. The number of sets is a parameter. `SET_BITS` = 12 gives 4096 sets, which is the 192 KB arrangement. The default build uses `SET_BITS` = 8 to keep the model small. The memories are held inside the block as arrays.

Top module: `cache3_lookup`

## Requirements
- R1: The address splits into byte [1:0], word [3:2], set [SET_BITS+3:4] and tag [31:SET_BITS+4]. With the default `SET_BITS` = 8, the set field is [11:4] and the tag field is [31:12].
- R2: `rsp_valid` is high in the cycle after a cycle with `rd_en` high, and low otherwise. `hit`, `hit_way` and `rd_word` belong to that response.
- R3: `hit` is 1 when exactly one way has its valid bit set and a stored tag equal to the address tag. `hit_way` then gives that way's number, which is 0, 1 or 2.
- R4: On a hit, `rd_word` is word `rd_addr[3:2]` of the hit way. Word w of a line occupies line bits [32w+31:32w], and byte b occupies bits [8b+7:8b].
- R5: When there is no hit, `hit`, `hit_way` and `rd_word` are all 0.
- R6: A fill writes byte b of `fill_data` into the chosen way only where `fill_be[b]` is 1. Bytes left unmasked keep the value that way held before.
- R7: A fill whose tag is already valid in the set updates that way and creates no second copy. It does not move the set's round-robin pointer.
- R8: A fill that misses in a set with an empty way writes into the lowest-numbered empty way.
- R9: A fill that misses in a full set writes into the way named by that set's pointer, then advances the pointer 0→1→2→0. Each set has its own pointer.
- R10: When a read and a fill happen in the same cycle, the response reflects the contents from before the fill.
- R11: Reset clears every valid bit and every pointer to 0 and forces `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Lookup request |
| rd_addr | input | 32 | Lookup byte address |
| fill_en | input | 1 | Line write request |
| fill_addr | input | 32 | Line address of the fill |
| fill_data | input | 128 | Line data, byte b at bits [8b+7:8b] |
| fill_be | input | 16 | Byte mask for the fill |
| rsp_valid | output | 1 | Response present |
| hit | output | 1 | Exactly one way matched |
| hit_way | output | 2 | Matching way number |
| rd_word | output | 32 | Selected word of the matching way |

## Verification
The hardest state to reach from the ports is a full set whose round-robin pointer has already moved. In that state, an in-place update and a later miss fill must be told apart by which way gets replaced. The vector table first fills one set with three tags, then forces four evictions so the pointer wraps past 2. It then updates a resident line under a partial byte mask, and finally misses once more. That last miss must land on the way the pointer reached before the update. A second set is filled in between so that any sharing of pointers or way state between sets would show.

// File: rtl/cache3_pkg.sv
package cache3_pkg;
  localparam int NWAYS      = 3;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_BYTES = LINE_WORDS * WORD_W / 8;
  localparam int LINE_W     = LINE_WORDS * WORD_W;
  localparam int OFS_BITS   = $clog2(LINE_BYTES);

  typedef logic [1:0] way_t;

  // Round-robin step over three ways: 0 -> 1 -> 2 -> 0
  function automatic way_t rr_step(input way_t p);
    return (p == way_t'(NWAYS - 1)) ? way_t'(0) : p + way_t'(1);
  endfunction

  // Lowest-numbered way whose valid bit is clear
  function automatic way_t lowest_empty(input logic [NWAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (!v[i]) r = way_t'(i);
    return r;
  endfunction

  // Number of the set bit of a match vector (0 if none)
  function automatic way_t way_index(input logic [NWAYS-1:0] m);
    way_t r;
    r = '0;
    for (int i = 0; i < NWAYS; i++)
      if (m[i]) r = way_t'(i);
    return r;
  endfunction

  // Word w of a line
  function automatic logic [WORD_W-1:0] line_word(input logic [LINE_W-1:0] l,
                                                  input logic [1:0] w);
    logic [WORD_W-1:0] r;
    case (w)
      2'd0:    r = l[0*WORD_W +: WORD_W];
      2'd1:    r = l[1*WORD_W +: WORD_W];
      2'd2:    r = l[2*WORD_W +: WORD_W];
      default: r = l[3*WORD_W +: WORD_W];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cache3_way.sv
module cache3_way
  import cache3_pkg::*;
#(
  parameter int SET_BITS = 8,
  parameter int TAG_W    = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_BITS-1:0]   rd_set,
  output logic                  q_valid,
  output logic [TAG_W-1:0]      q_tag,
  output logic [LINE_W-1:0]     q_line,
  input  logic [SET_BITS-1:0]   pr_set,
  output logic                  pr_valid,
  output logic [TAG_W-1:0]      pr_tag,
  input  logic                  wr_en,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [LINE_W-1:0]     wr_line,
  input  logic [LINE_BYTES-1:0] wr_be
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]     valid_mem;
  logic [TAG_W-1:0]    tag_mem  [SETS];
  logic [LINE_W-1:0]   data_mem [SETS];

  // Probe port used by the fill side (combinational read)
  assign pr_valid = valid_mem[pr_set];
  assign pr_tag   = tag_mem[pr_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_mem <= '0;
      q_valid   <= 1'b0;
    end else begin
      q_valid <= valid_mem[rd_set];
      if (wr_en) valid_mem[pr_set] <= 1'b1;
    end
  end

  // Tag and line stores: registered read, old contents on a same-cycle write
  always_ff @(posedge clk) begin
    q_tag  <= tag_mem[rd_set];
    q_line <= data_mem[rd_set];
    if (wr_en) tag_mem[pr_set] <= wr_tag;
    for (int b = 0; b < LINE_BYTES; b++)
      if (wr_en && wr_be[b]) data_mem[pr_set][b*8 +: 8] <= wr_line[b*8 +: 8];
  end
endmodule

// File: rtl/cache3_victim.sv
module cache3_victim
  import cache3_pkg::*;
#(
  parameter int SET_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [NWAYS-1:0]    way_valid,
  input  logic [NWAYS-1:0]    way_match,
  output way_t                victim,
  output logic [NWAYS-1:0]    victim_oh
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0][1:0] rr_mem;
  logic                 use_rr;

  assign use_rr = !(|way_match) && (&way_valid);

  always_comb begin
    if (|way_match)       victim = way_index(way_match);
    else if (!use_rr)     victim = lowest_empty(way_valid);
    else                  victim = rr_mem[fill_set];
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_oh
    assign victim_oh[w] = (victim == way_t'(w));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_mem <= '0;
    else if (fill_en && use_rr) rr_mem[fill_set] <= rr_step(rr_mem[fill_set]);
  end
endmodule

// File: rtl/cache3_lookup.sv
module cache3_lookup
  import cache3_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [127:0]      fill_data,
  input  logic [15:0]       fill_be,
  output logic              rsp_valid,
  output logic              hit,
  output logic [1:0]        hit_way,
  output logic [31:0]       rd_word
);
  localparam int TAG_W = ADDR_W - SET_BITS - OFS_BITS;

  logic [SET_BITS-1:0] rd_set, fill_set;
  logic [TAG_W-1:0]    rd_tag, fill_tag, q_cmp_tag;
  logic [1:0]          q_word;

  logic [NWAYS-1:0]    q_valid_w, pr_valid_w;
  logic [TAG_W-1:0]    q_tag_w  [NWAYS];
  logic [TAG_W-1:0]    pr_tag_w [NWAYS];
  logic [LINE_W-1:0]   q_line_w [NWAYS];

  // Named internal events, visible to the checker
  logic [NWAYS-1:0]    rd_match;
  logic [NWAYS-1:0]    fill_valid;
  logic [NWAYS-1:0]    fill_match;
  logic [NWAYS-1:0]    fill_oh;
  way_t                fill_way;
  way_t                match_way;
  logic                unused_bits;

  assign rd_set   = rd_addr[OFS_BITS +: SET_BITS];
  assign rd_tag   = rd_addr[ADDR_W-1 -: TAG_W];
  assign fill_set = fill_addr[OFS_BITS +: SET_BITS];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign unused_bits = ^{rd_addr[1:0], fill_addr[OFS_BITS-1:0]};

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    cache3_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (rd_set),
      .q_valid (q_valid_w[w]),
      .q_tag   (q_tag_w[w]),
      .q_line  (q_line_w[w]),
      .pr_set  (fill_set),
      .pr_valid(pr_valid_w[w]),
      .pr_tag  (pr_tag_w[w]),
      .wr_en   (fill_en && fill_oh[w]),
      .wr_tag  (fill_tag),
      .wr_line (fill_data),
      .wr_be   (fill_be)
    );
    assign rd_match[w]   = q_valid_w[w] && (q_tag_w[w] == q_cmp_tag);
    assign fill_valid[w] = pr_valid_w[w];
    assign fill_match[w] = pr_valid_w[w] && (pr_tag_w[w] == fill_tag);
  end

  cache3_victim #(.SET_BITS(SET_BITS)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .fill_set (fill_set),
    .way_valid(fill_valid),
    .way_match(fill_match),
    .victim   (fill_way),
    .victim_oh(fill_oh)
  );

  // Request stage register: tag and word travel beside the RAM read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      q_cmp_tag <= '0;
      q_word    <= '0;
    end else begin
      rsp_valid <= rd_en;
      q_cmp_tag <= rd_tag;
      q_word    <= rd_addr[3:2];
    end
  end

  assign match_way = way_index(rd_match);
  assign hit       = rsp_valid && $onehot(rd_match);
  assign hit_way   = hit ? match_way : 2'd0;
  assign rd_word   = hit ? line_word(q_line_w[match_way], q_word) : '0;
endmodule

// File: rtl/cache3_chk.sv
module cache3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        rsp_valid,
  input logic        hit,
  input logic [1:0]  hit_way,
  input logic [31:0] rd_word,
  input logic [2:0]  rd_match,
  input logic        fill_en,
  input logic [1:0]  fill_way,
  input logic [2:0]  fill_valid,
  input logic [2:0]  fill_match
);
  // R3: the fill policy never leaves two ways holding the same line
  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rd_match) <= 1));

  // R5: a miss drives quiet outputs
  a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_way == 2'd0 && rd_word == 32'd0));

  // R2: a hit only answers a request from the previous cycle
  a_r2_hit_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(rd_en));

  // R8: a miss fill into a set with room picks an empty way
  a_r8_empty_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(|fill_match) && !(&fill_valid)) |-> !fill_valid[fill_way]);

  // R7: a fill of a resident line reuses its way
  a_r7_update_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (|fill_match)) |-> fill_match[fill_way]);

  // R9: victim is always one of the three ways
  a_r9_victim_range: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (fill_way != 2'd3));

  // R11: reset leaves no response behind
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !hit));
endmodule

bind cache3_lookup cache3_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rsp_valid (rsp_valid),
  .hit       (hit),
  .hit_way   (hit_way),
  .rd_word   (rd_word),
  .rd_match  (rd_match),
  .fill_en   (fill_en),
  .fill_way  (fill_way),
  .fill_valid(fill_valid),
  .fill_match(fill_match)
);

// File: tb/cache3_lookup_test.sv
module cache3_lookup_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_en = 1'b0;
  logic [31:0]  rd_addr = '0;
  logic         fill_en = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [127:0] fill_data = '0;
  logic [15:0]  fill_be = '0;
  logic         rsp_valid, hit;
  logic [1:0]   hit_way;
  logic [31:0]  rd_word;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cache3_lookup uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_be(fill_be), .rsp_valid(rsp_valid), .hit(hit),
    .hit_way(hit_way), .rd_word(rd_word)
  );

  // R1: default split, tag [31:12], set [11:4], word [3:2]
  function automatic logic [31:0] mk(input logic [19:0] t, input logic [7:0] s,
                                     input logic [1:0] w);
    return {t, s, w, 2'b00};
  endfunction

  function automatic logic [127:0] mk_line(input logic [31:0] seed);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = seed + 32'(w);
    return l;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [31:0] seed,
                         input logic [15:0] be);
    @(negedge clk);
    fill_en = 1'b1; fill_addr = a; fill_data = mk_line(seed); fill_be = be;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, input bit ehit,
                         input logic [1:0] eway, input logic [31:0] eword);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rsp_valid == 1'b1, "R2 rsp_valid", 32'(rsp_valid), 32'd1);
    check(hit == ehit, ehit ? "R3 hit" : "R5 miss", 32'(hit), 32'(ehit));
    check(hit_way == eway, "R3 hit_way", 32'(hit_way), 32'(eway));
    check(rd_word == eword, ehit ? "R4 rd_word" : "R5 rd_word", rd_word, eword);
  endtask

  typedef struct packed {
    logic        op;     // 0 fill, 1 read
    logic [19:0] tag;
    logic [7:0]  set;
    logic [1:0]  word;
    logic [15:0] be;
    logic [31:0] seed;
    logic        ehit;
    logic [1:0]  eway;
    logic [31:0] eword;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 20'h1, 8'h05, 2'd0, 16'h0,    32'h0,      1'b0, 2'd0, 32'h0},        // R5
    '{1'b0, 20'h1, 8'h05, 2'd0, 16'hFFFF, 32'h100,    1'b0, 2'd0, 32'h0},        // R8 way0
    '{1'b1, 20'h1, 8'h05, 2'd2, 16'h0,    32'h0,      1'b1, 2'd0, 32'h102},      // R4
    '{1'b0, 20'h2, 8'h05, 2'd0, 16'hFFFF, 32'h200,    1'b0, 2'd0, 32'h0},        // R8 way1
    '{1'b0, 20'h3, 8'h05, 2'd0, 16'hFFFF, 32'h300,    1'b0, 2'd0, 32'h0},        // R8 way2
    '{1'b1, 20'h2, 8'h05, 2'd3, 16'h0,    32'h0,      1'b1, 2'd1, 32'h203},      // R3
    '{1'b1, 20'h3, 8'h05, 2'd1, 16'h0,    32'h0,      1'b1, 2'd2, 32'h301},      // R3
    '{1'b0, 20'h4, 8'h05, 2'd0, 16'hFFFF, 32'h400,    1'b0, 2'd0, 32'h0},        // R9 ptr0
    '{1'b1, 20'h1, 8'h05, 2'd0, 16'h0,    32'h0,      1'b0, 2'd0, 32'h0},        // R9 evicted
    '{1'b1, 20'h4, 8'h05, 2'd0, 16'h0,    32'h0,      1'b1, 2'd0, 32'h400},
    '{1'b0, 20'h5, 8'h05, 2'd0, 16'hFFFF, 32'h500,    1'b0, 2'd0, 32'h0},        // R9 ptr1
    '{1'b1, 20'h2, 8'h05, 2'd0, 16'h0,    32'h0,      1'b0, 2'd0, 32'h0},
    '{1'b1, 20'h5, 8'h05, 2'd1, 16'h0,    32'h0,      1'b1, 2'd1, 32'h501},
    '{1'b0, 20'h6, 8'h05, 2'd0, 16'hFFFF, 32'h600,    1'b0, 2'd0, 32'h0},        // R9 ptr2
    '{1'b1, 20'h6, 8'h05, 2'd2, 16'h0,    32'h0,      1'b1, 2'd2, 32'h602},
    '{1'b0, 20'h7, 8'h05, 2'd0, 16'hFFFF, 32'h700,    1'b0, 2'd0, 32'h0},        // R9 wrap
    '{1'b1, 20'h7, 8'h05, 2'd3, 16'h0,    32'h0,      1'b1, 2'd0, 32'h703},
    '{1'b1, 20'h4, 8'h05, 2'd0, 16'h0,    32'h0,      1'b0, 2'd0, 32'h0},
    '{1'b0, 20'hA, 8'h09, 2'd0, 16'hFFFF, 32'hA00,    1'b0, 2'd0, 32'h0},        // R1 other set
    '{1'b1, 20'hA, 8'h09, 2'd1, 16'h0,    32'h0,      1'b1, 2'd0, 32'hA01},
    '{1'b0, 20'h5, 8'h09, 2'd0, 16'hFFFF, 32'h5500,   1'b0, 2'd0, 32'h0},
    '{1'b1, 20'h5, 8'h09, 2'd0, 16'h0,    32'h0,      1'b1, 2'd1, 32'h5500},
    '{1'b1, 20'h5, 8'h05, 2'd0, 16'h0,    32'h0,      1'b1, 2'd1, 32'h500},      // R1 set kept apart
    '{1'b0, 20'h6, 8'h05, 2'd0, 16'h00F0, 32'h900,    1'b0, 2'd0, 32'h0},        // R7 + R6
    '{1'b1, 20'h6, 8'h05, 2'd1, 16'h0,    32'h0,      1'b1, 2'd2, 32'h901},
    '{1'b1, 20'h6, 8'h05, 2'd0, 16'h0,    32'h0,      1'b1, 2'd2, 32'h600},
    '{1'b1, 20'h6, 8'h05, 2'd3, 16'h0,    32'h0,      1'b1, 2'd2, 32'h603},
    '{1'b0, 20'h8, 8'h05, 2'd0, 16'hFFFF, 32'h800,    1'b0, 2'd0, 32'h0},        // R9 ptr still 1
    '{1'b1, 20'h8, 8'h05, 2'd2, 16'h0,    32'h0,      1'b1, 2'd1, 32'h802},
    '{1'b1, 20'h7, 8'h05, 2'd0, 16'h0,    32'h0,      1'b1, 2'd0, 32'h700},
    '{1'b1, 20'h5, 8'h05, 2'd0, 16'h0,    32'h0,      1'b0, 2'd0, 32'h0},
    '{1'b0, 20'h8, 8'h05, 2'd0, 16'h0001, 32'hFF,     1'b0, 2'd0, 32'h0},        // R6 byte0
    '{1'b1, 20'h8, 8'h05, 2'd0, 16'h0,    32'h0,      1'b1, 2'd1, 32'h8FF},
    '{1'b1, 20'h8, 8'h05, 2'd1, 16'h0,    32'h0,      1'b1, 2'd1, 32'h801},
    '{1'b0, 20'h8, 8'h05, 2'd0, 16'h8000, 32'hAB000000, 1'b0, 2'd0, 32'h0},      // R6 byte15
    '{1'b1, 20'h8, 8'h05, 2'd3, 16'h0,    32'h0,      1'b1, 2'd1, 32'hAB000803}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    // R11: reset state
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check(hit == 1'b0, "R11 hit in reset", 32'(hit), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op)
        do_read(mk(VEC[i].tag, VEC[i].set, VEC[i].word),
                VEC[i].ehit, VEC[i].eway, VEC[i].eword);
      else
        do_fill(mk(VEC[i].tag, VEC[i].set, 2'd0), VEC[i].seed, VEC[i].be);
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 idle rsp_valid", 32'(rsp_valid), 32'd0);

    // R10: read and miss fill of the same line in one cycle (pointer 2 -> way2)
    @(negedge clk);
    rd_en = 1'b1; rd_addr = mk(20'h9, 8'h05, 2'd0);
    fill_en = 1'b1; fill_addr = mk(20'h9, 8'h05, 2'd0);
    fill_data = mk_line(32'h900); fill_be = 16'hFFFF;
    @(negedge clk);
    rd_en = 1'b0; fill_en = 1'b0;
    check(hit == 1'b0, "R10 same-cycle read sees old", 32'(hit), 32'd0);
    do_read(mk(20'h9, 8'h05, 2'd0), 1'b1, 2'd2, 32'h900);   // R9 pointer at 2
    do_read(mk(20'h6, 8'h05, 2'd0), 1'b0, 2'd0, 32'h0);

    // R11: mid-run reset clears valid bits and pointers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    do_read(mk(20'h7, 8'h05, 2'd0), 1'b0, 2'd0, 32'h0);     // R11 line gone
    do_fill(mk(20'hB, 8'h05, 2'd0), 32'hB00, 16'hFFFF);
    do_read(mk(20'hB, 8'h05, 2'd1), 1'b1, 2'd0, 32'hB01);   // R8 after R11

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule